// File: doc/BRIEF.md
# Receive Byte Deserializer with Frame-Gap Detection

The block sits behind a bit correlator. Each bit time the correlator raises a strobe, together with a flag that says whether a valid bit was correlated and the bit value itself. In byte mode the block optionally complements each bit and shifts it in, most significant bit first. It hands finished bytes to two storage slots, A and B, which are used alternately. When a programmable number of bit times pass without valid data after a valid reception, the block declares the end of a frame. A partial byte is then flushed into the current slot. In bit-serial mode no bytes are assembled, and each strobed bit is passed straight through to a registered output pair.

Software reaches the block through a small synchronous register port. The port gives access to control, pin style, interrupt enables, a status word and the two data slots. Each slot has four interrupt sources: full, end of frame, overflow and underflow. The enabled sources are ORed into one request. That request drives an interrupt pin, modelled as a drive value plus an output enable, in one of four electrical styles.

Top module: `rx_gap_deser`

## Requirements
- R1: After reset the register map reads as follows: control (address 0) = 0x00, pin style (address 1) = 0x01, interrupt enable (address 2) = 0x00, status (address 3) = 0x00. The interrupt pin then shows irq_oe_o=1 and irq_o=0.
- R2: Control bit 0 set selects byte mode. Bits with bit_vld_i=1 on a bit_stb_i cycle shift in MSB first. The eighth bit stores the byte in the current slot and sets that slot's full flag on the same clock edge. Slots alternate, starting with A after reset. Status holds slot A in bits 3:0 and slot B in bits 7:4, each nibble ordered {underflow, overflow, eof, full} from bit 3 down to bit 0. Slot A data reads at address 4 and slot B data at address 5.
- R3: Control bit 1 set complements every received bit before it is used, both in byte mode and in bit-serial mode.
- R4: Control bits 4:2 hold a gap length G. Once at least one valid bit has arrived since the last end of frame, G+1 consecutive strobes with bit_vld_i=0 raise the eof flag of the current slot. A valid bit restarts the count. Invalid strobes that follow no valid bit raise nothing.
- R5: At end of frame, if k bits (1 to 7) of a byte are pending, they are stored right-aligned in the current slot. That slot's full flag is then set and the block moves on to the other slot. With no bits pending, no data is stored and the slot does not change.
- R6: With control bit 0 clear, each strobe shows up one cycle later on raw_vld_o (=bit_vld_i) and raw_bit_o. No bytes are assembled and no status flag is set. In byte mode raw_vld_o stays 0.
- R7: A slot that becomes full while its full flag is already set gets its overflow flag set, and the new byte replaces the old one.
- R8: Reading the data address of a slot whose full flag is clear sets that slot's underflow flag.
- R9: Reading the status address clears all eof, overflow and underflow flags. Reading a slot's data address clears that slot's full flag.
- R10: The interrupt request is the OR of the status bits ANDed with the enable register, bit for bit. Pin style 2'b01 gives oe=1 and drive=request. Style 2'b00 gives oe=1 and drive=!request. Style 2'b10 gives oe=request and drive=1. Style 2'b11 gives oe=request and drive=0.
- R11: Control bits 7:5 and pin-style bits 7:2 read 0 and ignore writes. Writes to status, to the data addresses and to addresses 6 and 7 change nothing, and addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_stb_i | input | 1 | One-cycle strobe per received bit time |
| bit_vld_i | input | 1 | Valid data was correlated in this bit time |
| bit_dat_i | input | 1 | Received bit value |
| reg_we_i | input | 1 | Register write |
| reg_re_i | input | 1 | Register read; read side effects apply at the clock edge |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from the address |
| raw_vld_o | output | 1 | Bit-serial mode: valid bit passed through |
| raw_bit_o | output | 1 | Bit-serial mode: bit value after optional inversion |
| irq_o | output | 1 | Interrupt pin drive value |
| irq_oe_o | output | 1 | Interrupt pin output enable (0 = high impedance) |

## Verification
The assertions assume that reads and strobes are single-cycle pulses. They also assume that a slot is never read on the same edge that refills it, and that the gap length is not rewritten while invalid bit times are being counted. The stimulus drives every input on the falling edge and issues register accesses only between bits. It rewrites the control register only just after a valid bit or an end of frame, so the gap counter is always at zero when the gap length changes. Random bytes, partial-frame lengths, gap lengths and inversion settings are drawn from a fixed seed, and each frame is fully drained before the next one starts.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int unsigned REG_AW = 3;
  localparam logic [REG_AW-1:0] ADR_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] ADR_PIN   = 3'd1;
  localparam logic [REG_AW-1:0] ADR_IEN   = 3'd2;
  localparam logic [REG_AW-1:0] ADR_STAT  = 3'd3;
  localparam logic [REG_AW-1:0] ADR_DAT_A = 3'd4;

  typedef enum logic [1:0] {
    PIN_PP_LOW  = 2'b00,
    PIN_PP_HIGH = 2'b01,
    PIN_SRC     = 2'b10,
    PIN_DRAIN   = 2'b11
  } pin_style_e;

  typedef struct packed {
    logic udf;
    logic ovf;
    logic eof;
    logic full;
  } slot_flags_t;

  localparam int unsigned FLAG_W = $bits(slot_flags_t);
endpackage

// File: rtl/rxd_cfg_regs.sv
module rxd_cfg_regs
  import rxd_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned GAP_W  = 3,
  parameter int unsigned NSLOT  = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [REG_AW-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic                      byte_en_o,
  output logic                      rx_inv_o,
  output logic [GAP_W-1:0]          gap_len_o,
  output pin_style_e                pin_style_o,
  output logic [NSLOT*FLAG_W-1:0]   irq_en_o
);
  localparam int unsigned IEN_W = NSLOT * FLAG_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_en_o   <= 1'b0;
      rx_inv_o    <= 1'b0;
      gap_len_o   <= '0;
      pin_style_o <= PIN_PP_HIGH;
      irq_en_o    <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADR_CTRL: begin
          byte_en_o <= wdata_i[0];
          rx_inv_o  <= wdata_i[1];
          gap_len_o <= wdata_i[2 +: GAP_W];
        end
        ADR_PIN: pin_style_o <= pin_style_e'(wdata_i[1:0]);
        ADR_IEN: irq_en_o    <= wdata_i[IEN_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rxd_bit_asm.sv
module rxd_bit_asm #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned GAP_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              vld_i,
  input  logic              dat_i,
  input  logic              byte_en_i,
  input  logic              rx_inv_i,
  input  logic [GAP_W-1:0]  gap_len_i,
  output logic              fill_o,
  output logic              eof_o,
  output logic [DATA_W-1:0] word_o,
  output logic              raw_vld_o,
  output logic              raw_bit_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [GAP_W-1:0]  gap_q;
  logic              armed_q;
  logic              bit_c, take_c, miss_c, done_c, eof_c;

  assign bit_c  = dat_i ^ rx_inv_i;
  assign take_c = byte_en_i & stb_i & vld_i;
  assign miss_c = byte_en_i & stb_i & ~vld_i & armed_q;
  assign done_c = take_c & (cnt_q == CNT_W'(DATA_W-1));
  assign eof_c  = miss_c & (gap_q == gap_len_i);

  assign fill_o = done_c | (eof_c & (cnt_q != '0));
  assign eof_o  = eof_c;
  assign word_o = done_c ? {sr_q[DATA_W-2:0], bit_c} : sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      gap_q   <= '0;
      armed_q <= 1'b0;
    end else if (!byte_en_i) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      gap_q   <= '0;
      armed_q <= 1'b0;
    end else if (take_c) begin
      armed_q <= 1'b1;
      gap_q   <= '0;
      if (done_c) begin
        sr_q  <= '0;
        cnt_q <= '0;
      end else begin
        sr_q  <= {sr_q[DATA_W-2:0], bit_c};
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (miss_c) begin
      if (eof_c) begin
        sr_q    <= '0;
        cnt_q   <= '0;
        gap_q   <= '0;
        armed_q <= 1'b0;
      end else begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  // bit-serial passthrough
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_vld_o <= 1'b0;
      raw_bit_o <= 1'b0;
    end else begin
      raw_vld_o <= stb_i & vld_i & ~byte_en_i;
      raw_bit_o <= bit_c;
    end
  end

  assert_eof_disarms_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_c |=> !armed_q);

  assert_raw_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_en_i |=> !raw_vld_o);
endmodule

// File: rtl/rxd_slot_bank.sv
module rxd_slot_bank
  import rxd_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NSLOT  = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          fill_i,
  input  logic                          eof_i,
  input  logic [DATA_W-1:0]             word_i,
  input  logic [NSLOT-1:0]              rd_data_i,
  input  logic                          rd_stat_i,
  output slot_flags_t [NSLOT-1:0]       flags_o,
  output logic [NSLOT-1:0][DATA_W-1:0]  data_o
);
  localparam int unsigned PTR_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (fill_i) ptr_q <= (ptr_q == PTR_W'(NSLOT-1)) ? '0 : ptr_q + 1'b1;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic              sel;
    slot_flags_t       flg_q;
    logic [DATA_W-1:0] dat_q;

    assign sel = (ptr_q == PTR_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flg_q <= '0;
        dat_q <= '0;
      end else begin
        if (rd_stat_i) begin
          flg_q.eof <= 1'b0;
          flg_q.ovf <= 1'b0;
          flg_q.udf <= 1'b0;
        end
        if (rd_data_i[g]) begin
          if (flg_q.full) flg_q.full <= 1'b0;
          else            flg_q.udf  <= 1'b1;
        end
        // new events win over clears on the same edge
        if (fill_i && sel) begin
          dat_q      <= word_i;
          flg_q.full <= 1'b1;
          if (flg_q.full && !rd_data_i[g]) flg_q.ovf <= 1'b1;
        end
        if (eof_i && sel) flg_q.eof <= 1'b1;
      end
    end

    assign flags_o[g] = flg_q;
    assign data_o[g]  = dat_q;

    assert_ovf_with_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flg_q.ovf) |-> flg_q.full);
  end

  if (NSLOT > 1) begin : g_ptr_chk
    assert_slot_alternate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fill_i |=> ptr_q != $past(ptr_q));
  end
endmodule

// File: rtl/rxd_pin_drv.sv
module rxd_pin_drv
  import rxd_pkg::*;
(
  input  pin_style_e style_i,
  input  logic       act_i,
  output logic       irq_o,
  output logic       irq_oe_o
);
  always_comb begin
    case (style_i)
      PIN_PP_LOW:  begin irq_o = ~act_i; irq_oe_o = 1'b1;  end
      PIN_PP_HIGH: begin irq_o = act_i;  irq_oe_o = 1'b1;  end
      PIN_SRC:     begin irq_o = 1'b1;   irq_oe_o = act_i; end
      default:     begin irq_o = 1'b0;   irq_oe_o = act_i; end
    endcase
  end
endmodule

// File: rtl/rx_gap_deser.sv
module rx_gap_deser
  import rxd_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned GAP_W  = 3,
  parameter int unsigned NSLOT  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_stb_i,
  input  logic              bit_vld_i,
  input  logic              bit_dat_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              raw_vld_o,
  output logic              raw_bit_o,
  output logic              irq_o,
  output logic              irq_oe_o
);
  localparam int unsigned IEN_W = NSLOT * FLAG_W;

  logic                         byte_en, rx_inv;
  logic [GAP_W-1:0]             gap_len;
  pin_style_e                   pin_style;
  logic [IEN_W-1:0]             irq_en;
  logic                         fill, eof;
  logic [DATA_W-1:0]            word;
  logic [NSLOT-1:0]             rd_data;
  logic                         rd_stat;
  slot_flags_t [NSLOT-1:0]      flags;
  logic [NSLOT-1:0][DATA_W-1:0] slot_data;
  logic                         irq_act;

  rxd_cfg_regs #(.DATA_W(DATA_W), .GAP_W(GAP_W), .NSLOT(NSLOT)) u_cfg (
    .clk_i, .rst_ni,
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .byte_en_o  (byte_en),
    .rx_inv_o   (rx_inv),
    .gap_len_o  (gap_len),
    .pin_style_o(pin_style),
    .irq_en_o   (irq_en)
  );

  rxd_bit_asm #(.DATA_W(DATA_W), .GAP_W(GAP_W)) u_asm (
    .clk_i, .rst_ni,
    .stb_i     (bit_stb_i),
    .vld_i     (bit_vld_i),
    .dat_i     (bit_dat_i),
    .byte_en_i (byte_en),
    .rx_inv_i  (rx_inv),
    .gap_len_i (gap_len),
    .fill_o    (fill),
    .eof_o     (eof),
    .word_o    (word),
    .raw_vld_o (raw_vld_o),
    .raw_bit_o (raw_bit_o)
  );

  assign rd_stat = reg_re_i & (reg_addr_i == ADR_STAT);
  for (genvar g = 0; g < NSLOT; g++) begin : g_rd
    assign rd_data[g] = reg_re_i & (reg_addr_i == ADR_DAT_A + REG_AW'(g));
  end

  rxd_slot_bank #(.DATA_W(DATA_W), .NSLOT(NSLOT)) u_slots (
    .clk_i, .rst_ni,
    .fill_i    (fill),
    .eof_i     (eof),
    .word_i    (word),
    .rd_data_i (rd_data),
    .rd_stat_i (rd_stat),
    .flags_o   (flags),
    .data_o    (slot_data)
  );

  assign irq_act = |(flags & irq_en);

  rxd_pin_drv u_pin (
    .style_i  (pin_style),
    .act_i    (irq_act),
    .irq_o    (irq_o),
    .irq_oe_o (irq_oe_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADR_CTRL: begin
        reg_rdata_o[0]         = byte_en;
        reg_rdata_o[1]         = rx_inv;
        reg_rdata_o[2 +: GAP_W] = gap_len;
      end
      ADR_PIN:  reg_rdata_o[1:0]       = pin_style;
      ADR_IEN:  reg_rdata_o[IEN_W-1:0] = irq_en;
      ADR_STAT: reg_rdata_o[IEN_W-1:0] = flags;
      default: begin
        for (int s = 0; s < NSLOT; s++)
          if (reg_addr_i == ADR_DAT_A + REG_AW'(s)) reg_rdata_o = slot_data[s];
      end
    endcase
  end

  assert_pin_push_pull_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_style == PIN_PP_HIGH) |-> (irq_oe_o && (irq_o == |(flags & irq_en))));

  assert_drain_hiz_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_style == PIN_DRAIN && (flags & irq_en) == '0) |-> !irq_oe_o);

  assert_empty_read_udf_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data[0] && !flags[0].full) |=> flags[0].udf);
endmodule

// File: tb/tb_rx_gap_deser.sv
module tb_rx_gap_deser;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb = 0, vld = 0, dat = 0;
  logic       we = 0, re = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       raw_vld, raw_bit, irq, irq_oe;

  int checks = 0;
  int fails  = 0;
  logic ptr = 1'b0;  // bench's own slot pointer: 0 = A, 1 = B
  logic [7:0] v;

  always #10 clk = ~clk;  // 50 MHz

  rx_gap_deser dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bit_stb_i(stb), .bit_vld_i(vld), .bit_dat_i(dat),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .raw_vld_o(raw_vld), .raw_bit_o(raw_bit),
    .irq_o(irq), .irq_oe_o(irq_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    re = 1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    re = 0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic send_bit(input logic v_i, input logic d_i);
    stb = 1; vld = v_i; dat = d_i;
    @(negedge clk);
    stb = 0; vld = 0; dat = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic inv);
    for (int i = 7; i >= 0; i--) send_bit(1'b1, b[i] ^ inv);
    ptr = ~ptr;
  endtask

  task automatic send_gap(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0, 1'b0);
  endtask

  function automatic logic [7:0] full_bit(input logic p);
    return p ? 8'h10 : 8'h01;
  endfunction

  function automatic logic [7:0] eof_bit(input logic p);
    return p ? 8'h20 : 8'h02;
  endfunction

  function automatic logic [2:0] dat_adr(input logic p);
    return p ? 3'd5 : 3'd4;
  endfunction

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd_chk("R1 ctrl", 3'd0, 8'h00);
    rd_chk("R1 pin", 3'd1, 8'h01);
    rd_chk("R1 ien", 3'd2, 8'h00);
    rd_chk("R1 stat", 3'd3, 8'h00);
    check("R1 pin idle", {6'd0, irq_oe, irq}, 8'h02);

    // R11: reserved bits and read-only addresses
    wr(3'd0, 8'hFF); rd_chk("R11 ctrl reserved", 3'd0, 8'h1F);
    wr(3'd1, 8'hFF); rd_chk("R11 pin reserved", 3'd1, 8'h03);
    wr(3'd3, 8'hFF); rd_chk("R11 stat ro", 3'd3, 8'h00);
    wr(3'd6, 8'hFF); rd_chk("R11 unused addr", 3'd6, 8'h00);
    wr(3'd1, 8'h01); wr(3'd0, 8'h00);

    // R6 / R3: bit-serial passthrough
    send_bit(1'b1, 1'b1);
    check("R6 raw pass", {6'd0, raw_vld, raw_bit}, 8'h03);
    @(negedge clk);
    check("R6 raw idle", {7'd0, raw_vld}, 8'h00);
    wr(3'd0, 8'h02);
    send_bit(1'b1, 1'b1);
    check("R3 raw invert", {6'd0, raw_vld, raw_bit}, 8'h02);
    send_bit(1'b0, 1'b1);
    check("R6 invalid no raw", {7'd0, raw_vld}, 8'h00);
    for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b1);
    send_gap(2);
    rd_chk("R6 no flags in bit mode", 3'd3, 8'h00);

    // R2: byte assembly into slot A, gap 0
    wr(3'd0, 8'h01);
    send_bit(1'b1, 1'b1);
    check("R6 byte mode raw quiet", {7'd0, raw_vld}, 8'h00);
    for (int i = 6; i >= 0; i--) send_bit(1'b1, 8'hA5 >> i);  // remaining 7 bits of 0xA5 after leading 1
    ptr = ~ptr;
    rd_chk("R2 full A", 3'd3, 8'h01);
    rd_chk("R2 data A", 3'd4, 8'hA5);
    rd_chk("R9 full cleared by read", 3'd3, 8'h00);

    // R4: gap 0 fires on first invalid, no partial
    send_gap(1);
    rd_chk("R4 eof gap0 on B", 3'd3, 8'h20);
    rd_chk("R9 eof cleared", 3'd3, 8'h00);
    send_gap(3);
    rd_chk("R4 no eof when unarmed", 3'd3, 8'h00);

    // R4/R5: gap 3 with restart and partial flush
    wr(3'd0, 8'h0D);
    send_bit(1'b1, 1'b1); send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b1);
    send_gap(3);
    rd_chk("R4 gap not yet expired", 3'd3, 8'h00);
    send_bit(1'b1, 1'b1);
    send_gap(3);
    rd_chk("R4 count restarted", 3'd3, 8'h00);
    send_gap(1);
    rd_chk("R5 partial flush to B", 3'd3, 8'h30);
    rd_chk("R5 partial data", 3'd5, 8'h0B);
    ptr = ~ptr;

    // R7: overflow
    wr(3'd0, 8'h01);
    send_byte(8'h11, 1'b0);
    send_byte(8'h22, 1'b0);
    send_byte(8'h33, 1'b0);
    rd_chk("R7 overflow A", 3'd3, 8'h15);
    rd_chk("R7 newest byte kept", 3'd4, 8'h33);
    rd_chk("R2 slot B byte", 3'd5, 8'h22);
    send_gap(1);
    rd_chk("R4 eof after bytes", 3'd3, eof_bit(ptr));

    // R8: underflow on empty read
    rd(3'd4, v);
    rd_chk("R8 underflow A", 3'd3, 8'h08);
    rd_chk("R9 underflow cleared", 3'd3, 8'h00);

    // R10: pin styles
    wr(3'd2, 8'h10);
    send_byte(8'h5A, 1'b0);
    check("R10 pp high active", {6'd0, irq_oe, irq}, 8'h03);
    wr(3'd1, 8'h00); check("R10 pp low active", {6'd0, irq_oe, irq}, 8'h02);
    wr(3'd1, 8'h02); check("R10 source active", {6'd0, irq_oe, irq}, 8'h03);
    wr(3'd1, 8'h03); check("R10 drain active", {6'd0, irq_oe, irq}, 8'h02);
    rd_chk("R2 data B", 3'd5, 8'h5A);
    check("R10 drain idle hiz", {7'd0, irq_oe}, 8'h00);
    wr(3'd1, 8'h02); check("R10 source idle hiz", {7'd0, irq_oe}, 8'h00);
    wr(3'd1, 8'h00); check("R10 pp low idle", {6'd0, irq_oe, irq}, 8'h03);
    wr(3'd1, 8'h01);
    wr(3'd2, 8'h00);
    send_byte(8'h77, 1'b0);
    check("R10 masked source", {6'd0, irq_oe, irq}, 8'h02);
    rd_chk("R2 data A masked case", 3'd4, 8'h77);

    // Random frames: byte then partial then gap
    for (int it = 0; it < 40; it++) begin
      logic       inv;
      logic [2:0] gap;
      logic [7:0] b, p, pexp;
      int         k;
      inv = 1'($urandom);
      gap = 3'($urandom);
      b   = 8'($urandom);
      p   = 8'($urandom);
      k   = 1 + int'($urandom % 7);
      pexp = p & ((8'h01 << k) - 8'h01);
      wr(3'd0, {3'b000, gap, inv, 1'b1});
      send_byte(b, inv);
      rd_chk("R2 R3 random full", 3'd3, full_bit(~ptr));
      rd_chk("R3 random data", dat_adr(~ptr), b);
      for (int i = k - 1; i >= 0; i--) send_bit(1'b1, p[i] ^ inv);
      send_gap(int'(gap));
      rd_chk("R4 random pre-gap", 3'd3, 8'h00);
      send_gap(1);
      rd_chk("R5 random flush", 3'd3, full_bit(ptr) | eof_bit(ptr));
      rd_chk("R5 random partial", dat_adr(ptr), pexp);
      ptr = ~ptr;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule